// File: doc/BRIEF.md
# Serial-Wire Debug Power-Up Handshake Engine

This block is the host side of a two-wire serial debug link. Once the far-end debug port is already in serial-wire mode, a single `start` pulse makes the engine ask the target for debug and system power and wait until the target grants both. It does this through the port's control/status register, and builds every transaction bit by bit. That covers the request header, the turnaround periods, the 3-bit acknowledge, the 32 data bits and the parity bit.

The sequence has two phases. In the first phase the engine writes a value that raises both power-up requests and also clears the sticky error flag. It then reads the register back repeatedly until both acknowledge bits are set. In the second phase it writes the request bits again, without the sticky clear, and polls once more. When the second poll succeeds, `done` goes high.

A retry budget sets how many attempts each phase may use. The block raises `error` in three cases: the budget runs out, the target answers with a fault or an undefined acknowledge, or read data arrives with bad parity. The last good status word read is always visible on `ctrl_status`.

Top module: `dbg_pwrup_engine`

## Requirements
- R1: After reset the serial clock is low, the data line is driven low with its enable high, `done` and `error` are low, and `ctrl_status` is zero.
- R2: Each high phase and each low phase of the serial clock lasts `clk_div`+1 system clocks while a transaction runs. The data output and its enable change only when the clock falls, and never during a high phase. The host samples the line at the end of each high phase.
- R3: Every request is 8 bits, sent first bit first, in this order: start bit 1, port-select 0 (debug port), direction (1 = read), address bit 2 = 1, address bit 3 = 0, even parity over those four fields, stop bit 0, park bit 1. On the wire a write request is therefore 1,0,0,1,0,1,0,1 and a read request is 1,0,1,1,0,0,0,1.
- R4: A write runs in this order: request, one turnaround bit, 3 acknowledge bits, one turnaround bit, 32 data bits (bit 0 first), then one even-parity bit. The output enable is low during both turnaround bits and the acknowledge bits.
- R5: A read runs in this order: request, one turnaround bit, 3 acknowledge bits, 32 data bits (bit 0 first), one parity bit, then one turnaround bit before the host drives the line again. There is no turnaround between the acknowledge and the data.
- R6: The first write carries 0x50000020 and the second write carries 0x50000000. Each write is followed by reads of the register. `done` rises only after a read in the second phase returns bit 31 and bit 29 both set, and `ctrl_status` then holds that word.
- R7: A read with only one of bits 31 and 29 set counts as not ready, and polling continues.
- R8: The acknowledge bit received first is bit 0. The value 3'b001 means OK. The value 3'b010 means WAIT, and the same transaction is sent again. Any other value ends the sequence with `error`.
- R9: Each phase has an attempt budget of max(`timeout`,1). Every WAIT and every read without both acknowledge bits uses one attempt. The error is raised when the attempt that reaches the budget fails. The budget refills when the second phase begins.
- R10: A read whose parity bit does not make the 33 bits even ends the sequence with `error`, and `ctrl_status` is not updated.
- R11: `done` and `error` hold their values until the next accepted `start`. A `start` during a running sequence is ignored.
- R12: `done` and `error` are never high together, and the serial clock is low whenever either one is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the handshake when the engine is idle |
| clk_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| timeout | input | TO_W | Attempt budget for each phase |
| swclk_o | output | 1 | Serial clock to the target |
| swdio_o | output | 1 | Serial data driven by the host |
| swdio_oe | output | 1 | High while the host drives the data line |
| swdio_i | input | 1 | Serial data line as seen at the host |
| done | output | 1 | Handshake complete; both power domains acknowledged |
| error | output | 1 | Handshake aborted |
| ctrl_status | output | 32 | Last status word read with good acknowledge and parity |

## Verification
The assertions assume three things about the inputs. `clk_div` and `timeout` stay constant while a sequence runs, `start` is a synchronous pulse, and the target drives the data line only while the host enable is low. The target model in the bench follows this: it takes the line only in the acknowledge and read-data slots and releases it in the turnaround slots, with a pull-up value at all other times. Every test sets the divider and budget before it pulses `start` and leaves them alone until `done` or `error` rises. One test also sends a second `start` pulse in the middle of a run, to show that the pulse is ignored and does not upset the sequence.

// File: rtl/dbg_pwr_pkg.sv
package dbg_pwr_pkg;

    localparam int DW = 32;

    // acknowledge codes, first received bit in bit 0
    localparam logic [2:0] ACK_OK   = 3'b001;
    localparam logic [2:0] ACK_WAIT = 3'b010;

    // control/status register address bits [3:2]
    localparam logic [1:0] CTRL_ADDR = 2'b01;

    localparam logic [DW-1:0] CTRL_W1 = 32'h5000_0020;  // power requests + sticky clear
    localparam logic [DW-1:0] CTRL_W2 = 32'h5000_0000;  // power requests only

    localparam int SYS_ACK_BIT = 31;
    localparam int DBG_ACK_BIT = 29;

    typedef enum logic [3:0] {
        L_IDLE, L_REQ, L_TRN1, L_ACK, L_TRN2, L_WDAT, L_WPAR,
        L_RDAT, L_RPAR, L_TEND, L_FIN
    } link_st_e;

    typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} seq_st_e;

    // request header, bit 0 goes out first:
    // start, port select, direction, A2, A3, parity, stop, park
    function automatic logic [7:0] req_byte(input logic ap, input logic rnw,
                                            input logic [1:0] addr);
        return {1'b1, 1'b0, ^{ap, rnw, addr}, addr[1], addr[0], rnw, ap, 1'b1};
    endfunction

endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             swclk,
    output logic             bit_end
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             hi;
    } tmr_t;

    tmr_t q, d;
    logic wrap;

    always_comb begin
        wrap = (q.cnt >= div);
        d    = q;
        if (!run) begin
            d = '0;
        end else if (wrap) begin
            d.cnt = '0;
            d.hi  = !q.hi;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign swclk   = q.hi;
    assign bit_end = run && q.hi && wrap;

endmodule

// File: rtl/swd_link.sv
module swd_link
    import dbg_pwr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          rnw,
    input  logic [DW-1:0] wdata,
    input  logic          bit_end,
    input  logic          din,
    output logic          run,
    output logic          dout,
    output logic          oe,
    output logic          fin,
    output logic [2:0]    ack,
    output logic [DW-1:0] rdata,
    output logic          par_ok
);
    localparam logic [5:0] LAST_BIT = 6'(DW - 1);

    typedef struct packed {
        link_st_e      st;
        logic [5:0]    cnt;
        logic [DW-1:0] sh;
        logic [2:0]    ack;
        logic          rnw;
        logic          dout;
        logic          oe;
        logic          par_ok;
    } link_t;

    localparam link_t LINK_RST = '{st: L_IDLE, cnt: '0, sh: '0, ack: '0,
                                   rnw: 1'b0, dout: 1'b0, oe: 1'b1, par_ok: 1'b1};

    link_t q, d;
    logic [7:0] req;
    logic [2:0] ack_nx;

    always_comb begin
        req    = req_byte(1'b0, rnw, CTRL_ADDR);
        ack_nx = {din, q.ack[2:1]};
        d      = q;
        if (q.st == L_IDLE) begin
            if (go) begin
                d.st     = L_REQ;
                d.rnw    = rnw;
                d.sh     = {{(DW-8){1'b0}}, req};
                d.dout   = req[0];
                d.oe     = 1'b1;
                d.cnt    = '0;
                d.par_ok = 1'b1;
            end
        end else if (q.st == L_FIN) begin
            d.st = L_IDLE;
        end else if (bit_end) begin
            case (q.st)
                L_REQ: begin
                    if (q.cnt == 6'd7) begin
                        d.st  = L_TRN1;
                        d.oe  = 1'b0;
                        d.cnt = '0;
                    end else begin
                        d.cnt  = q.cnt + 6'd1;
                        d.sh   = q.sh >> 1;
                        d.dout = q.sh[1];
                    end
                end
                L_TRN1: begin
                    d.st  = L_ACK;
                    d.cnt = '0;
                end
                L_ACK: begin
                    d.ack = ack_nx;
                    if (q.cnt == 6'd2) begin
                        d.cnt = '0;
                        if (ack_nx != ACK_OK) d.st = L_TEND;
                        else if (q.rnw)       d.st = L_RDAT;
                        else                  d.st = L_TRN2;
                    end else begin
                        d.cnt = q.cnt + 6'd1;
                    end
                end
                L_TRN2: begin
                    d.st   = L_WDAT;
                    d.oe   = 1'b1;
                    d.sh   = wdata;
                    d.dout = wdata[0];
                    d.cnt  = '0;
                end
                L_WDAT: begin
                    if (q.cnt == LAST_BIT) begin
                        d.st   = L_WPAR;
                        d.dout = ^wdata;
                    end else begin
                        d.cnt  = q.cnt + 6'd1;
                        d.sh   = q.sh >> 1;
                        d.dout = q.sh[1];
                    end
                end
                L_WPAR: begin
                    d.st   = L_FIN;
                    d.oe   = 1'b1;
                    d.dout = 1'b0;
                end
                L_RDAT: begin
                    d.sh = {din, q.sh[DW-1:1]};
                    if (q.cnt == LAST_BIT) d.st = L_RPAR;
                    else                   d.cnt = q.cnt + 6'd1;
                end
                L_RPAR: begin
                    d.par_ok = ~^{q.sh, din};
                    d.st     = L_TEND;
                end
                L_TEND: begin
                    d.st   = L_FIN;
                    d.oe   = 1'b1;
                    d.dout = 1'b0;
                end
                default: d.st = L_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= LINK_RST;
        else        q <= d;
    end

    assign run    = (q.st != L_IDLE) && (q.st != L_FIN);
    assign fin    = (q.st == L_FIN);
    assign dout   = q.dout;
    assign oe     = q.oe;
    assign ack    = q.ack;
    assign rdata  = q.sh;
    assign par_ok = q.par_ok;

endmodule

// File: rtl/dbg_pwrup_engine.sv
module dbg_pwrup_engine
    import dbg_pwr_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int TO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [TO_W-1:0]  timeout,
    output logic             swclk_o,
    output logic             swdio_o,
    output logic             swdio_oe,
    input  logic             swdio_i,
    output logic             done,
    output logic             error,
    output logic [DW-1:0]    ctrl_status
);
    typedef struct packed {
        seq_st_e       st;
        logic          phase;
        logic [TO_W-1:0] tries;
        logic          go;
        logic          rnw;
        logic [DW-1:0] wdata;
        logic          done;
        logic          err;
        logic [DW-1:0] status;
    } seq_t;

    seq_t q, d;

    logic          lk_run, lk_fin, lk_par, bit_end;
    logic [2:0]    lk_ack;
    logic [DW-1:0] lk_rdata;
    logic [TO_W:0] lim, tries_nx;
    logic          last_try, ready;

    swd_bit_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(lk_run), .div(clk_div),
        .swclk(swclk_o), .bit_end(bit_end)
    );

    swd_link u_link (
        .clk(clk), .rst_n(rst_n), .go(q.go), .rnw(q.rnw), .wdata(q.wdata),
        .bit_end(bit_end), .din(swdio_i), .run(lk_run), .dout(swdio_o),
        .oe(swdio_oe), .fin(lk_fin), .ack(lk_ack), .rdata(lk_rdata),
        .par_ok(lk_par)
    );

    always_comb begin
        lim      = (timeout == '0) ? (TO_W+1)'(1) : {1'b0, timeout};
        tries_nx = {1'b0, q.tries} + 1'b1;
        last_try = (tries_nx >= lim);
        ready    = lk_rdata[SYS_ACK_BIT] && lk_rdata[DBG_ACK_BIT];
        d        = q;
        d.go     = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.done  = 1'b0;
                    d.err   = 1'b0;
                    d.phase = 1'b0;
                    d.tries = '0;
                    d.go    = 1'b1;
                    d.rnw   = 1'b0;
                    d.wdata = CTRL_W1;
                    d.st    = S_WR;
                end
            end
            S_WR: begin
                if (lk_fin) begin
                    if (lk_ack == ACK_OK) begin
                        d.go  = 1'b1;
                        d.rnw = 1'b1;
                        d.st  = S_RD;
                    end else if (lk_ack == ACK_WAIT && !last_try) begin
                        d.tries = tries_nx[TO_W-1:0];
                        d.go    = 1'b1;
                    end else begin
                        d.err = 1'b1;
                        d.st  = S_IDLE;
                    end
                end
            end
            S_RD: begin
                if (lk_fin) begin
                    if (lk_ack == ACK_OK && lk_par) begin
                        d.status = lk_rdata;
                        if (ready && !q.phase) begin
                            d.phase = 1'b1;
                            d.tries = '0;
                            d.go    = 1'b1;
                            d.rnw   = 1'b0;
                            d.wdata = CTRL_W2;
                            d.st    = S_WR;
                        end else if (ready) begin
                            d.done = 1'b1;
                            d.st   = S_IDLE;
                        end else if (!last_try) begin
                            d.tries = tries_nx[TO_W-1:0];
                            d.go    = 1'b1;
                        end else begin
                            d.err = 1'b1;
                            d.st  = S_IDLE;
                        end
                    end else if (lk_ack == ACK_WAIT && !last_try) begin
                        d.tries = tries_nx[TO_W-1:0];
                        d.go    = 1'b1;
                    end else begin
                        d.err = 1'b1;
                        d.st  = S_IDLE;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign done        = q.done;
    assign error       = q.err;
    assign ctrl_status = q.status;

endmodule

// File: rtl/dbg_pwrup_engine_chk.sv
module dbg_pwrup_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic swclk_o,
    input logic swdio_o,
    input logic swdio_oe,
    input logic done,
    input logic error,
    input logic sys_ack,
    input logic dbg_ack
);
    assert_flags_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_clk_parked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !swclk_o);

    assert_data_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk_o && $past(swclk_o)) |-> $stable(swdio_o));

    assert_oe_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk_o && $past(swclk_o)) |-> $stable(swdio_oe));

    assert_ready_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (sys_ack && dbg_ack));

    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_error_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

endmodule

bind dbg_pwrup_engine dbg_pwrup_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .swclk_o(swclk_o),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .done(done), .error(error),
    .sys_ack(ctrl_status[31]), .dbg_ack(ctrl_status[29])
);

// File: tb/sim_dbg_pwrup_engine.sv
`timescale 1ns/1ps
module sim_dbg_pwrup_engine;
    localparam int DIV_W = 8;
    localparam int TO_W  = 8;

    logic clk, rst_n, start;
    logic [DIV_W-1:0] clk_div;
    logic [TO_W-1:0]  timeout;
    wire  swclk_o, swdio_o, swdio_oe, done, error;
    wire  [31:0] ctrl_status;
    logic tgt_oe, tgt_d;
    wire  swdio_i = tgt_oe ? tgt_d : 1'b1;

    dbg_pwrup_engine #(.DIV_W(DIV_W), .TO_W(TO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_div(clk_div),
        .timeout(timeout), .swclk_o(swclk_o), .swdio_o(swdio_o),
        .swdio_oe(swdio_oe), .swdio_i(swdio_i), .done(done), .error(error),
        .ctrl_status(ctrl_status)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0, errors = 0;

    // target configuration (written by tests only)
    int polls_req = 0, wait_end = 0, fault_at = -1, bad_par_at = -1, exp_half = 2;
    logic [31:0] part_val = 32'h5000_0000;

    // target / monitor counters (written by target or monitor only)
    int txn_n = 0, rd_n = 0, wr_n = 0, ph_rd = 0, req_bad = 0, wpar_bad = 0;
    int hi_len = 0, hi_bad = 0, dchg_bad = 0, clash = 0;
    logic [31:0] wlog [0:63];
    logic pv_clk = 1'b0, pv_dout = 1'b0;

    // target model: one action per rising serial clock edge
    initial begin : target
        logic [7:0]  rq;
        logic [2:0]  ak;
        logic [31:0] dv;
        logic        pb;
        int          idx;
        tgt_oe = 1'b0;
        tgt_d  = 1'b0;
        forever begin
            @(posedge swclk_o);
            if (swdio_oe && swdio_o) begin
                rq = 8'h01;
                for (int i = 1; i < 8; i++) begin
                    @(posedge swclk_o);
                    rq[i] = swdio_o;
                    if (!swdio_oe) req_bad++;
                end
                if (rq != 8'hA9 && rq != 8'h8D) req_bad++;
                @(posedge swclk_o);                       // turnaround
                if (txn_n < wait_end)    ak = 3'b010;
                else if (txn_n == fault_at) ak = 3'b100;
                else                     ak = 3'b001;
                txn_n++;
                for (int i = 0; i < 3; i++) begin
                    @(posedge swclk_o);
                    tgt_oe = 1'b1;
                    tgt_d  = ak[i];
                end
                if (ak != 3'b001) begin
                    @(posedge swclk_o);
                    tgt_oe = 1'b0;
                end else if (rq == 8'hA9) begin
                    @(posedge swclk_o);
                    tgt_oe = 1'b0;
                    for (int i = 0; i < 32; i++) begin
                        @(posedge swclk_o);
                        dv[i] = swdio_o;
                    end
                    @(posedge swclk_o);
                    pb = swdio_o;
                    if (pb != ^dv) wpar_bad++;
                    wlog[wr_n % 64] = dv;
                    wr_n++;
                    ph_rd = 0;
                end else begin
                    dv = (ph_rd < polls_req) ? part_val : 32'hF000_0000;
                    idx = rd_n;
                    ph_rd++;
                    rd_n++;
                    for (int i = 0; i < 32; i++) begin
                        @(posedge swclk_o);
                        tgt_d = dv[i];
                    end
                    @(posedge swclk_o);
                    tgt_d = (^dv) ^ (idx == bad_par_at);
                    @(posedge swclk_o);
                    tgt_oe = 1'b0;
                end
            end
        end
    end

    // line monitor: half-period length, data stability, bus clashes
    always @(negedge clk) begin
        if (rst_n) begin
            if (swdio_oe && tgt_oe) clash++;
            if (swclk_o) begin
                hi_len++;
                if (pv_clk && swdio_o != pv_dout) dchg_bad++;
            end else if (pv_clk) begin
                if (hi_len != exp_half) hi_bad++;
                hi_len = 0;
            end
        end
        pv_clk  = swclk_o;
        pv_dout = swdio_o;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run_seq(input int div, input int to);
        clk_div  = DIV_W'(div);
        timeout  = TO_W'(to);
        exp_half = div + 1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(done || error)) @(negedge clk);
    endtask

    task automatic line_clean(input string tag);
        chk(req_bad == 0,  "R3", {tag, " request headers"}, req_bad, 0);
        chk(wpar_bad == 0, "R4", {tag, " write parity"}, wpar_bad, 0);
        chk(clash == 0,    "R5", {tag, " bus clash"}, clash, 0);
        chk(hi_bad == 0,   "R2", {tag, " high phase length"}, hi_bad, 0);
        chk(dchg_bad == 0, "R2", {tag, " data change while high"}, dchg_bad, 0);
    endtask

    task automatic t_reset();
        chk(swclk_o == 1'b0,  "R1", "reset swclk", swclk_o, 0);
        chk(swdio_oe == 1'b1, "R1", "reset oe", swdio_oe, 1);
        chk(swdio_o == 1'b0,  "R1", "reset data", swdio_o, 0);
        chk(!done && !error,  "R1", "reset flags", {done, error}, 0);
        chk(ctrl_status == 0, "R1", "reset status", ctrl_status, 0);
    endtask

    task automatic t_basic();
        int w0 = wr_n, r0 = rd_n;
        polls_req = 2; part_val = 32'h5000_0000;
        run_seq(1, 8);
        chk(done && !error, "R6", "basic done", {done, error}, 2);
        chk(ctrl_status == 32'hF000_0000, "R6", "basic status", ctrl_status, 32'hF000_0000);
        chk(wr_n - w0 == 2, "R6", "basic writes", wr_n - w0, 2);
        chk(wlog[w0 % 64] == 32'h5000_0020, "R6", "first write value", wlog[w0 % 64], 32'h5000_0020);
        chk(wlog[(w0 + 1) % 64] == 32'h5000_0000, "R4", "second write value", wlog[(w0 + 1) % 64], 32'h5000_0000);
        chk(rd_n - r0 == 6, "R5", "basic reads", rd_n - r0, 6);
        line_clean("basic");
    endtask

    task automatic t_div();
        int r0 = rd_n;
        polls_req = 0;
        run_seq(3, 4);
        chk(done && !error, "R2", "slow clock done", {done, error}, 2);
        chk(rd_n - r0 == 2, "R2", "slow clock reads", rd_n - r0, 2);
        line_clean("divider 3");
    endtask

    task automatic t_partial();
        int r0 = rd_n;
        polls_req = 3; part_val = 32'hD000_0000;
        run_seq(1, 8);
        chk(done && !error, "R7", "partial ack done", {done, error}, 2);
        chk(rd_n - r0 == 8, "R7", "partial ack reads", rd_n - r0, 8);
        chk(ctrl_status == 32'hF000_0000, "R7", "partial ack status", ctrl_status, 32'hF000_0000);
    endtask

    task automatic t_wait();
        int t0 = txn_n, w0 = wr_n;
        polls_req = 0;
        wait_end = txn_n + 2;
        run_seq(1, 8);
        chk(done && !error, "R8", "wait retry done", {done, error}, 2);
        chk(txn_n - t0 == 6, "R8", "wait retry transactions", txn_n - t0, 6);
        chk(wr_n - w0 == 2, "R8", "wait retry writes", wr_n - w0, 2);
    endtask

    task automatic t_fault();
        int t0 = txn_n, w0 = wr_n, r0 = rd_n;
        polls_req = 0;
        fault_at = txn_n + 1;
        run_seq(1, 8);
        chk(error && !done, "R8", "fault aborts", {done, error}, 1);
        chk(txn_n - t0 == 2, "R8", "fault transactions", txn_n - t0, 2);
        chk(wr_n - w0 == 1 && rd_n == r0, "R8", "fault data moves", wr_n - w0, 1);
        fault_at = -1;
    endtask

    task automatic t_timeout();
        int r0 = rd_n;
        polls_req = 10; part_val = 32'h5000_0000;
        run_seq(1, 3);
        chk(error && !done, "R9", "timeout error", {done, error}, 1);
        chk(rd_n - r0 == 3, "R9", "timeout reads", rd_n - r0, 3);
        chk(ctrl_status == 32'h5000_0000, "R9", "timeout status", ctrl_status, 32'h5000_0000);
        r0 = rd_n;
        run_seq(1, 0);
        chk(error && !done, "R9", "zero budget error", {done, error}, 1);
        chk(rd_n - r0 == 1, "R9", "zero budget reads", rd_n - r0, 1);
    endtask

    task automatic t_parity();
        int r0 = rd_n;
        logic [31:0] s0 = ctrl_status;
        polls_req = 0;
        bad_par_at = rd_n;
        run_seq(1, 8);
        chk(error && !done, "R10", "bad read parity", {done, error}, 1);
        chk(rd_n - r0 == 1, "R10", "bad parity reads", rd_n - r0, 1);
        chk(ctrl_status == s0, "R10", "status kept", ctrl_status, s0);
        bad_par_at = -1;
    endtask

    task automatic t_hold();
        int w0 = wr_n, r0 = rd_n;
        polls_req = 1;
        clk_div = '0; timeout = TO_W'(8); exp_half = 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!(done || error)) @(negedge clk);
        chk(wr_n - w0 == 2, "R11", "restart ignored writes", wr_n - w0, 2);
        chk(rd_n - r0 == 4, "R11", "restart ignored reads", rd_n - r0, 4);
        repeat (50) @(negedge clk);
        chk(done && !error, "R11", "done held", {done, error}, 2);
        chk(!swclk_o, "R12", "clock parked", swclk_o, 0);
        line_clean("divider 0");
    endtask

    initial begin : main
        rst_n = 1'b0; start = 1'b0; clk_div = 8'd1; timeout = 8'd8;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_div();
        t_partial();
        t_wait();
        t_fault();
        t_timeout();
        t_parity();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule